// File: doc/BRIEF.md
# Load-Store Function Unit with Shared Address Adder

This block is one function unit of a scoreboarded processor core. It accepts one operation at a time from the issue logic. It asks the dependency tracker for its operands with a go-read strobe and computes a result on its own adder. For memory operations it masters a simple request/acknowledge memory bus. When there is a result, it asks for permission to write it back with a go-write strobe.

The unit uses the same adder in two ways. For loads and stores the adder forms the effective address as base plus offset. For add and subtract it forms the arithmetic result, and those operations skip the bus phase entirely.

The sequencer has five named states:
- `ST_IDLE` (issue acceptance)
- `ST_OPREAD` (go-read)
- `ST_ADDR` (adder)
- `ST_BUSDRV` (bus request)
- `ST_WBACK` (go-write)

Its transitions are:
- idle→opread on an accepted issue
- opread→addr on read grant
- addr→busdrv for load/store
- addr→wback for add/sub
- busdrv→wback on acknowledge of a load
- busdrv→idle on acknowledge of a store
- wback→idle on write grant

Synchronous reset forces idle from any state.

Top module: `lsfu_core`

## Requirements
- R1: `issue_op` encodes 2'b00 load, 2'b01 store, 2'b10 add, 2'b11 subtract. An issue is accepted only when `busy` is low. `busy` is high from the cycle after acceptance until the operation ends.
- R2: In the cycle after acceptance `go_read` rises. It stays high until `read_grant` is seen. Operands `opnd_a`, `opnd_b` and `opnd_c` are captured in the grant cycle, and later changes have no effect.
- R3: The adder phase lasts exactly one cycle. Add yields `opnd_a + opnd_b` and subtract yields `opnd_a - opnd_b`, both modulo 2^DATA_W.
- R4: A load or store raises `mem_req` in the cycle after the adder phase, with `mem_addr = opnd_a + opnd_b` modulo 2^DATA_W. `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold steady until `mem_ack`, for any number of wait cycles.
- R5: A load captures `mem_rdata` in the acknowledge cycle and presents it on `result` during write-back.
- R6: A store drives `mem_we` = 1 and `mem_wdata = opnd_c`. After the acknowledge it returns to idle without raising `go_write`.
- R7: Add and subtract never raise `mem_req`. They raise `go_write` in the cycle after the adder phase.
- R8: `go_write` and `result` hold steady until `write_grant`. `busy` falls in the following cycle.
- R9: With no wait cycles, a load reaches write-back four cycles after its issue cycle (five cycles inclusive), and an add or subtract reaches it three cycles after.
- R10: An issue presented while `busy` is high is ignored and leaves the running operation's result unchanged.
- R11: Synchronous reset returns the unit to idle and clears `busy`, `go_read`, `go_write` and `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | Issue strobe |
| issue_op | input | 2 | Operation code (see R1) |
| busy | output | 1 | Unit occupied |
| go_read | output | 1 | Operand read request |
| read_grant | input | 1 | Operands valid and granted |
| opnd_a | input | DATA_W | Base / first operand |
| opnd_b | input | DATA_W | Offset / second operand |
| opnd_c | input | DATA_W | Store data |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write enable |
| mem_addr | output | DATA_W | Bus address |
| mem_wdata | output | DATA_W | Bus write data |
| mem_ack | input | 1 | Bus acknowledge |
| mem_rdata | input | DATA_W | Bus read data |
| go_write | output | 1 | Result write request |
| write_grant | input | 1 | Write-back granted |
| result | output | DATA_W | Result value |

## Verification
The bench builds the unit with DATA_W = 8. At that width, address wraparound past the top of the space and subtract borrow (0 - 1 giving 8'hFF) are reachable with small hand-picked operand values. Equal operands on subtract give a zero result. The vector table mixes zero-wait and multi-wait handshakes on read grant, bus acknowledge and write grant, so every state's hold behaviour and both zero-wait latencies are covered at that width.

// File: rtl/lsfu_pkg.sv
package lsfu_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_ADD   = 2'b10,
        OP_SUB   = 2'b11
    } lsfu_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPREAD,
        ST_ADDR,
        ST_BUSDRV,
        ST_WBACK
    } lsfu_state_e;

    function automatic logic op_is_mem(input lsfu_op_e op);
        return (op == OP_LOAD) || (op == OP_STORE);
    endfunction

endpackage

// File: rtl/lsfu_adder.sv
module lsfu_adder #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum
);
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   carry;

    assign b_eff    = b ^ {DATA_W{sub}};
    assign carry[0] = sub;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
    end

    logic carry_out_unused;
    assign carry_out_unused = carry[DATA_W];
endmodule

// File: rtl/lsfu_seq.sv
module lsfu_seq
    import lsfu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        issue_valid,
    input  logic [1:0]  issue_op,
    input  logic        read_grant,
    input  logic        mem_ack,
    input  logic        write_grant,
    output lsfu_op_e    op_q,
    output logic        busy,
    output logic        go_read,
    output logic        go_write,
    output logic        mem_req,
    output logic        mem_we,
    output logic        opnd_load,
    output logic        sum_load,
    output logic        rdata_load
);
    lsfu_state_e state, nxt;
    logic        accept;

    assign accept = (state == ST_IDLE) && issue_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            op_q  <= OP_LOAD;
        end else begin
            state <= nxt;
            if (accept) op_q <= lsfu_op_e'(issue_op);
        end
    end

    always_comb begin
        nxt        = state;
        busy       = 1'b1;
        go_read    = 1'b0;
        go_write   = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        opnd_load  = 1'b0;
        sum_load   = 1'b0;
        rdata_load = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                if (issue_valid) nxt = ST_OPREAD;
            end
            ST_OPREAD: begin
                go_read = 1'b1;
                if (read_grant) begin
                    opnd_load = 1'b1;
                    nxt       = ST_ADDR;
                end
            end
            ST_ADDR: begin
                sum_load = 1'b1;
                nxt      = op_is_mem(op_q) ? ST_BUSDRV : ST_WBACK;
            end
            ST_BUSDRV: begin
                mem_req = 1'b1;
                mem_we  = (op_q == OP_STORE);
                if (mem_ack) begin
                    rdata_load = (op_q == OP_LOAD);
                    nxt        = (op_q == OP_STORE) ? ST_IDLE : ST_WBACK;
                end
            end
            ST_WBACK: begin
                go_write = 1'b1;
                if (write_grant) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // R2: read request holds until granted
    p_read_hold_r2: assert property (@(posedge clk) disable iff (rst)
        go_read && !read_grant |=> go_read);

    // R7: arithmetic operations never reach the bus
    p_alu_no_bus_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> op_is_mem(op_q));

    // R8: write request holds until granted
    p_write_hold_r8: assert property (@(posedge clk) disable iff (rst)
        go_write && !write_grant |=> go_write);

    // R10: issue while busy leaves the latched operation alone
    p_issue_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        busy && issue_valid |=> $stable(op_q));
endmodule

// File: rtl/lsfu_dpath.sv
module lsfu_dpath
    import lsfu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  lsfu_op_e          op_q,
    input  logic              opnd_load,
    input  logic              sum_load,
    input  logic              rdata_load,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] opnd_c,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] res_q,
    output logic [DATA_W-1:0] c_q
);
    logic [DATA_W-1:0] a_q, b_q, sum;

    lsfu_adder #(.DATA_W(DATA_W)) u_adder (
        .a   (a_q),
        .b   (b_q),
        .sub (op_q == OP_SUB),
        .sum (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            c_q   <= '0;
            res_q <= '0;
        end else begin
            if (opnd_load) begin
                a_q <= opnd_a;
                b_q <= opnd_b;
                c_q <= opnd_c;
            end
            if (sum_load)        res_q <= sum;
            else if (rdata_load) res_q <= mem_rdata;
        end
    end
endmodule

// File: rtl/lsfu_core.sv
module lsfu_core
    import lsfu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [1:0]        issue_op,
    output logic              busy,
    output logic              go_read,
    input  logic              read_grant,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] opnd_c,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              go_write,
    input  logic              write_grant,
    output logic [DATA_W-1:0] result
);
    lsfu_op_e          op_q;
    logic              opnd_load, sum_load, rdata_load;
    logic [DATA_W-1:0] res_q, c_q;

    lsfu_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .issue_valid (issue_valid),
        .issue_op    (issue_op),
        .read_grant  (read_grant),
        .mem_ack     (mem_ack),
        .write_grant (write_grant),
        .op_q        (op_q),
        .busy        (busy),
        .go_read     (go_read),
        .go_write    (go_write),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .opnd_load   (opnd_load),
        .sum_load    (sum_load),
        .rdata_load  (rdata_load)
    );

    lsfu_dpath #(.DATA_W(DATA_W)) u_dpath (
        .clk        (clk),
        .rst        (rst),
        .op_q       (op_q),
        .opnd_load  (opnd_load),
        .sum_load   (sum_load),
        .rdata_load (rdata_load),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .opnd_c     (opnd_c),
        .mem_rdata  (mem_rdata),
        .res_q      (res_q),
        .c_q        (c_q)
    );

    // One register carries the address during the bus phase and the result afterwards
    assign mem_addr  = res_q;
    assign mem_wdata = c_q;
    assign result    = res_q;

    // R1: accepted issue makes the unit busy and requests operands
    p_issue_busy_r1: assert property (@(posedge clk) disable iff (rst)
        !busy && issue_valid |=> busy && go_read);

    // R4: bus request and its fields hold until acknowledge
    p_bus_hold_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)
                                && $stable(mem_we) && $stable(mem_wdata));

    // R6: acknowledged store ends without write-back
    p_store_no_wb_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_ack |=> !busy && !go_write);

    // R8: result stays put while waiting for write grant
    p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
        go_write && !write_grant |=> $stable(result));

    // R11: reset clears the unit
    p_reset_clears_r11: assert property (@(posedge clk)
        rst |=> !busy && !go_read && !go_write && !mem_req);
endmodule

// File: tb/test_lsfu_core.sv
module test_lsfu_core;
    localparam int  DW      = 8;
    localparam time CLK_PER = 10ns;
    localparam int  NVEC    = 9;

    // entry: op,rwait,await,wwait (one hex digit each), a, b, c, rdata, expected, pad
    localparam logic [63:0] VEC [NVEC] = '{
        64'h0000_1005_00C3_C300,  // load, no waits
        64'h1000_F020_7E00_7E00,  // store, address wraps
        64'h2000_3C14_0000_5000,  // add
        64'h3000_0509_0000_FC00,  // sub negative
        64'h0231_FF02_0081_8100,  // load with waits, address wraps
        64'h1140_8080_A500_A500,  // store with waits
        64'h2303_C864_0000_2C00,  // add overflow, waits
        64'h3102_7777_0000_0000,  // sub equal
        64'h3000_0001_0000_FF00   // sub borrow
    };

    logic          clk = 1'b0, rst = 1'b1;
    logic          issue_valid = 1'b0, read_grant = 1'b0;
    logic          mem_ack = 1'b0, write_grant = 1'b0;
    logic [1:0]    issue_op = 2'b00;
    logic [DW-1:0] opnd_a = '0, opnd_b = '0, opnd_c = '0, mem_rdata = '0;
    logic          busy, go_read, go_write, mem_req, mem_we;
    logic [DW-1:0] mem_addr, mem_wdata, result;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    lsfu_core #(.DATA_W(DW)) i_lsfu_core (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
        .busy(busy), .go_read(go_read), .read_grant(read_grant),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .go_write(go_write), .write_grant(write_grant), .result(result)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [63:0] v);
        logic [1:0]    op = v[61:60];
        int            rw = int'(v[59:56]);
        int            aw = int'(v[55:52]);
        int            ww = int'(v[51:48]);
        logic [DW-1:0] a = v[47:40], b = v[39:32], c = v[31:24];
        logic [DW-1:0] rd = v[23:16], exp = v[15:8];
        logic [DW-1:0] addr = a + b;
        bit            is_mem = (op[1] == 1'b0);
        int            nc = 0;
        @(negedge clk);
        issue_valid = 1'b1; issue_op = op; opnd_a = a; opnd_b = b; opnd_c = c;
        @(negedge clk); nc++;
        issue_valid = 1'b0;
        chk(busy && go_read, "R1 busy+go_read after issue", {busy, go_read}, 2'b11);
        for (int k = 0; k < rw; k++) begin
            @(negedge clk); nc++;
            chk(go_read, "R2 go_read held", go_read, 1);
        end
        read_grant = 1'b1;
        @(negedge clk); nc++;
        read_grant = 1'b0; opnd_a = 8'hEE; opnd_b = 8'h11; opnd_c = 8'h33;
        chk(!go_read && !mem_req && !go_write, "R3 single adder cycle",
            {go_read, mem_req, go_write}, 0);
        @(negedge clk); nc++;
        if (is_mem) begin
            chk(mem_req && mem_addr == addr, "R4 bus address", mem_addr, addr);
            chk(mem_we == op[0], "R6 write enable", mem_we, op[0]);
            if (op[0]) chk(mem_wdata == c, "R6 store data", mem_wdata, c);
            for (int k = 0; k < aw; k++) begin
                @(negedge clk); nc++;
                chk(mem_req && mem_addr == addr, "R4 request held", mem_addr, addr);
            end
            mem_ack = 1'b1; mem_rdata = rd;
            @(negedge clk); nc++;
            mem_ack = 1'b0; mem_rdata = 8'h5A;
            if (op[0]) begin
                chk(!busy && !go_write && !mem_req, "R6 store ends without write-back",
                    {busy, go_write, mem_req}, 0);
                return;
            end
        end
        if (rw == 0 && aw == 0)
            chk(nc == (is_mem ? 4 : 3), "R9 zero-wait latency", nc, is_mem ? 4 : 3);
        chk(go_write && !mem_req, "R7 write-back without bus", {go_write, mem_req}, 2'b10);
        chk(result == exp, is_mem ? "R5 load data" : "R3 add/sub result", result, exp);
        for (int k = 0; k < ww; k++) begin
            @(negedge clk);
            chk(go_write && result == exp, "R8 result held", result, exp);
        end
        write_grant = 1'b1;
        @(negedge clk);
        write_grant = 1'b0;
        chk(!busy && !go_write, "R8 idle after grant", {busy, go_write}, 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(!busy && !go_read && !go_write && !mem_req, "R11 reset state",
            {busy, go_read, go_write, mem_req}, 0);

        for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

        // R10: issue of a store while an add runs is ignored
        @(negedge clk);
        issue_valid = 1'b1; issue_op = 2'b10; opnd_a = 8'h01; opnd_b = 8'h02;
        @(negedge clk);
        issue_op = 2'b01; read_grant = 1'b1;
        @(negedge clk);
        read_grant = 1'b0;
        @(negedge clk);
        issue_valid = 1'b0;
        chk(go_write && !mem_req && result == 8'h03, "R10 busy issue ignored",
            result, 8'h03);
        write_grant = 1'b1;
        @(negedge clk);
        write_grant = 1'b0;
        chk(!busy, "R10 idle after ignored issue", busy, 0);

        // R11: reset in the middle of a bus wait
        issue_valid = 1'b1; issue_op = 2'b00;
        @(negedge clk);
        issue_valid = 1'b0; read_grant = 1'b1;
        @(negedge clk);
        read_grant = 1'b0;
        @(negedge clk);
        chk(mem_req, "R4 request pending before reset", mem_req, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !go_read && !go_write && !mem_req, "R11 reset mid-operation",
            {busy, go_read, go_write, mem_req}, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule